// File: doc/BRIEF.md
# Smart card contact activation sequencer

This block brings up and shuts down the electrical contacts of an ISO-7816 style smart card. Software enables the interface and writes a non-zero supply code. The sequencer then turns the card supply on and waits for a supply-good indication within a programmable window. After that it releases the I/O line and the auxiliary contacts, ungates the card clock and releases card reset after a programmable count. Once reset is released it times the wait for the answer-to-reset. All delays are counted in card clock periods, which arrive as a one-cycle `cclk_tick` strobe from the clock generator.

Deactivation always runs in a fixed order, one card clock period per step: reset low, clock gated low, I/O low, auxiliary contacts low, supply off. Software starts it by clearing the enable or the supply code. A failed supply window starts it too. A loss of supply-good after power-up starts it at once and also sets a sticky fault flag. The supply code is never cleared by hardware. A further activation needs the code to pass through zero first. A hold-reset bit keeps card reset low and can be used to issue a warm reset while the card is active.

Top module: `sc_act_seq`

## Requirements
- R1: With `if_en`=1 and an armed non-zero `vsel` (01=1.8 V, 10=3.0 V, 11=5.0 V), `vcc_en` rises at the first tick after the request, and `vcc_code` equals `vsel` while the supply is on.
- R2: If the supply window (`vto_len` ticks after power-up, 0 treated as 1) ends without supply-good qualifying, deactivation starts at that tick. `io_rel` never rises, and `vcc_en` falls 4 ticks later.
- R3: With `rdy_start`=0, `io_rel` (and `aux_rel`) rise 2 ticks after the window end, provided `vcc_ok` was seen high by then. With `rdy_start`=1 they rise 2 ticks after the first tick that sees `vcc_ok` high inside the window.
- R4: `clk_en` rises 2 ticks after `io_rel` rises.
- R5: `card_rst_n` rises `rst_len` ticks after `clk_en` rises (0 treated as 1).
- R6: `atr_tmo` is set `atr_len` ticks after reset release unless `atr_start` came first. `atr_len`=0 disables it. `atr_start` moves the state to active. The flag is cleared when a new activation starts.
- R7: Deactivation drops `card_rst_n` on the next clock edge. Then `clk_en`, `io_rel`, `aux_rel` and `vcc_en` fall on the following four ticks, in that order. Clearing `if_en` or setting `vsel` to 0 starts it from any active state.
- R8: After an activation has started, a further one starts only once `vsel` has been seen as 0 and is then set non-zero.
- R9: `vcc_ok` low in any state from I/O release to active starts deactivation on the next edge and sets `fault`. `fault` stays set until a `fault_clr` pulse.
- R10: While `hold_rst`=1, `card_rst_n` stays low. After it clears, reset is released `rst_len` ticks later. Setting it in the ATR-wait or active state drops `card_rst_n` at the next tick.
- R11: `state_o` codes: 0 idle, 1 powering, 2 I/O release, 3 clock start, 4 reset wait, 5 ATR wait, 6 active, 7 deactivating.
- R12: After reset, all contact outputs, `fault` and `atr_tmo` are 0 and `state_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cclk_tick | input | 1 | One-cycle strobe per card clock period |
| if_en | input | 1 | Interface enable |
| vsel | input | 2 | Supply select code, 0 = off |
| vcc_ok | input | 1 | Supply-good from the regulator |
| rdy_start | input | 1 | Count I/O release delay from supply-good alone |
| hold_rst | input | 1 | Keep card reset asserted |
| vto_len | input | VTW | Supply window in ticks |
| rst_len | input | RLW | Clock-to-reset-release delay in ticks |
| atr_len | input | ATW | ATR timeout in ticks, 0 = off |
| atr_start | input | 1 | Receiver saw the ATR start bit |
| fault_clr | input | 1 | Clears the fault flag |
| vcc_en | output | 1 | Card supply enable |
| vcc_code | output | 2 | Selected supply level while on |
| io_rel | output | 1 | I/O line released high |
| aux_rel | output | 1 | Auxiliary contacts released |
| clk_en | output | 1 | Card clock gate |
| card_rst_n | output | 1 | Card reset line, low = asserted |
| atr_tmo | output | 1 | Sticky ATR timeout flag |
| fault | output | 1 | Sticky supply fault flag |
| state_o | output | 3 | Sequencer state code |

## Verification
Every result except the immediate reset drop and the fault flag changes on a tick edge. So the bench stamps each output edge with the count of ticks seen so far and compares stamps arithmetically: supply +1 after the request, I/O at the window end or supply-good tick +2, clock +2, reset +`rst_len`, ATR flag +`atr_len`, and the deactivation steps +1 each. Inputs change on the falling edge right after a counted tick, so the next tick is the first to see them. The reset drop on a fault or software stop and the fault flag are checked one clock later.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POWER  = 3'd1,
    ST_IOREL  = 3'd2,
    ST_CLKST  = 3'd3,
    ST_RSTW   = 3'd4,
    ST_ATRW   = 3'd5,
    ST_ACTIVE = 3'd6,
    ST_DEACT  = 3'd7
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sc_arm_detect.sv
module sc_arm_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic [1:0] vsel,
  input  logic       start_evt,
  output logic       start_req
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b1;
    else if (start_evt)     armed <= 1'b0;
    else if (vsel == 2'b00) armed <= 1'b1;
  end

  assign start_req = armed && if_en && (vsel != 2'b00);
endmodule

// File: rtl/sc_flags.sv
module sc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_evt,
  input  logic tmo_evt,
  input  logic start_evt,
  input  logic fault_clr,
  output logic fault,
  output logic atr_tmo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault   <= 1'b0;
      atr_tmo <= 1'b0;
    end else begin
      if (fault_evt)      fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;
      if (tmo_evt)        atr_tmo <= 1'b1;
      else if (start_evt) atr_tmo <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_pkg::*;
#(
  parameter int VTW     = 8,
  parameter int RLW     = 8,
  parameter int ATW     = 12,
  parameter int IO_DLY  = 2,
  parameter int CLK_DLY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           start_req,
  input  logic           if_en,
  input  logic [1:0]     vsel,
  input  logic           vcc_ok,
  input  logic           rdy_start,
  input  logic           hold_rst,
  input  logic [VTW-1:0] vto_len,
  input  logic [RLW-1:0] rst_len,
  input  logic [ATW-1:0] atr_len,
  input  logic           atr_start,
  output seq_state_t     st,
  output logic           vcc_en,
  output logic [1:0]     vcc_code,
  output logic           io_rel,
  output logic           aux_rel,
  output logic           clk_en,
  output logic           card_rst_n,
  output logic           start_evt,
  output logic           fault_evt,
  output logic           tmo_evt
);
  localparam int CW = imax(imax(VTW, RLW), imax(ATW, 4));

  logic [CW-1:0] cnt;
  logic [CW:0]   nxt, vto_x, rl_x, al_x;
  logic [1:0]    code_q;
  logic          vto_hit, live, stop_req;

  assign nxt     = {1'b0, cnt} + 1'b1;
  assign vto_x   = (CW+1)'(vto_len);
  assign rl_x    = (CW+1)'(rst_len);
  assign al_x    = (CW+1)'(atr_len);
  assign vto_hit = nxt >= vto_x;

  always_comb begin
    live      = (st == ST_IOREL) || (st == ST_CLKST) || (st == ST_RSTW) ||
                (st == ST_ATRW)  || (st == ST_ACTIVE);
    stop_req  = (st != ST_IDLE) && (st != ST_DEACT) && (!if_en || (vsel == 2'b00));
    fault_evt = live && !vcc_ok;
    start_evt = (st == ST_IDLE) && tick && start_req;
    tmo_evt   = (st == ST_ATRW) && tick && !atr_start && !hold_rst && !fault_evt &&
                !stop_req && ({1'b0, cnt} != al_x) && (nxt == al_x);
  end

  assign vcc_code = vcc_en ? code_q : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      code_q     <= 2'b00;
      vcc_en     <= 1'b0;
      io_rel     <= 1'b0;
      aux_rel    <= 1'b0;
      clk_en     <= 1'b0;
      card_rst_n <= 1'b0;
    end else if (fault_evt || stop_req) begin
      st         <= ST_DEACT;
      cnt        <= '0;
      card_rst_n <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_evt) begin
          st     <= ST_POWER;
          cnt    <= '0;
          vcc_en <= 1'b1;
          code_q <= vsel;
        end
        ST_POWER: if (tick) begin
          if (vcc_ok && (rdy_start || vto_hit)) begin
            st  <= ST_IOREL;
            cnt <= '0;
          end else if (vto_hit) begin
            st  <= ST_DEACT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_IOREL: if (tick) begin
          if (nxt >= (CW+1)'(IO_DLY)) begin
            st      <= ST_CLKST;
            cnt     <= '0;
            io_rel  <= 1'b1;
            aux_rel <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_CLKST: if (tick) begin
          if (nxt >= (CW+1)'(CLK_DLY)) begin
            st     <= ST_RSTW;
            cnt    <= '0;
            clk_en <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_RSTW: if (tick) begin
          if (hold_rst) cnt <= '0;
          else if (nxt >= rl_x) begin
            st         <= ST_ATRW;
            cnt        <= '0;
            card_rst_n <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_ATRW: begin
          if (atr_start) st <= ST_ACTIVE;
          else if (tick) begin
            if (hold_rst) begin
              st         <= ST_RSTW;
              cnt        <= '0;
              card_rst_n <= 1'b0;
            end else if ({1'b0, cnt} != al_x) cnt <= cnt + 1'b1;
          end
        end
        ST_ACTIVE: if (tick && hold_rst) begin
          st         <= ST_RSTW;
          cnt        <= '0;
          card_rst_n <= 1'b0;
        end
        ST_DEACT: if (tick) begin
          cnt <= cnt + 1'b1;
          case (cnt[1:0])
            2'd0:    clk_en  <= 1'b0;
            2'd1:    io_rel  <= 1'b0;
            2'd2:    aux_rel <= 1'b0;
            default: begin
              vcc_en <= 1'b0;
              st     <= ST_IDLE;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
  import sc_pkg::*;
#(
  parameter int VTW     = 8,
  parameter int RLW     = 8,
  parameter int ATW     = 12,
  parameter int IO_DLY  = 2,
  parameter int CLK_DLY = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cclk_tick,
  input  logic           if_en,
  input  logic [1:0]     vsel,
  input  logic           vcc_ok,
  input  logic           rdy_start,
  input  logic           hold_rst,
  input  logic [VTW-1:0] vto_len,
  input  logic [RLW-1:0] rst_len,
  input  logic [ATW-1:0] atr_len,
  input  logic           atr_start,
  input  logic           fault_clr,
  output logic           vcc_en,
  output logic [1:0]     vcc_code,
  output logic           io_rel,
  output logic           aux_rel,
  output logic           clk_en,
  output logic           card_rst_n,
  output logic           atr_tmo,
  output logic           fault,
  output logic [2:0]     state_o
);
  seq_state_t st;
  logic start_req, start_evt, fault_evt, tmo_evt;

  sc_arm_detect u_arm (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .vsel(vsel),
    .start_evt(start_evt), .start_req(start_req)
  );

  sc_seq_fsm #(
    .VTW(VTW), .RLW(RLW), .ATW(ATW), .IO_DLY(IO_DLY), .CLK_DLY(CLK_DLY)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(cclk_tick), .start_req(start_req),
    .if_en(if_en), .vsel(vsel), .vcc_ok(vcc_ok), .rdy_start(rdy_start),
    .hold_rst(hold_rst), .vto_len(vto_len), .rst_len(rst_len),
    .atr_len(atr_len), .atr_start(atr_start), .st(st),
    .vcc_en(vcc_en), .vcc_code(vcc_code), .io_rel(io_rel),
    .aux_rel(aux_rel), .clk_en(clk_en), .card_rst_n(card_rst_n),
    .start_evt(start_evt), .fault_evt(fault_evt), .tmo_evt(tmo_evt)
  );

  sc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .tmo_evt(tmo_evt),
    .start_evt(start_evt), .fault_clr(fault_clr),
    .fault(fault), .atr_tmo(atr_tmo)
  );

  assign state_o = st;
endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_ok,
  input logic       fault_clr,
  input logic       vcc_en,
  input logic       io_rel,
  input logic       aux_rel,
  input logic       clk_en,
  input logic       card_rst_n,
  input logic       fault,
  input logic [2:0] state_o
);
  AST_VCC_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!card_rst_n && !clk_en && !io_rel && !aux_rel)); // R7
  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_rel); // R4
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst_n |-> clk_en); // R5
  AST_IO_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rel || aux_rel) |-> vcc_en); // R3
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault); // R9
  AST_DROP_DEACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o >= 3'd2) && (state_o <= 3'd6) && !vcc_ok) |=> (state_o == 3'd7)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (!vcc_en && !io_rel && !clk_en && !card_rst_n)); // R11
endmodule

bind sc_act_seq sc_act_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .fault_clr(fault_clr),
  .vcc_en(vcc_en), .io_rel(io_rel), .aux_rel(aux_rel), .clk_en(clk_en),
  .card_rst_n(card_rst_n), .fault(fault), .state_o(state_o)
);

// File: tb/sc_act_seq_tb_top.sv
`timescale 1ns/1ps
module sc_act_seq_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, cclk_tick = 1'b0, if_en = 1'b0, vcc_ok = 1'b0;
  logic       rdy_start = 1'b0, hold_rst = 1'b0, atr_start = 1'b0, fault_clr = 1'b0;
  logic [1:0] vsel = 2'b00;
  logic [7:0] vto_len = 8'd1, rst_len = 8'd1;
  logic [11:0] atr_len = 12'd0;
  logic       vcc_en, io_rel, aux_rel, clk_en, card_rst_n, atr_tmo, fault;
  logic [1:0] vcc_code;
  logic [2:0] state_o;

  sc_act_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cclk_tick(cclk_tick), .if_en(if_en), .vsel(vsel),
    .vcc_ok(vcc_ok), .rdy_start(rdy_start), .hold_rst(hold_rst),
    .vto_len(vto_len), .rst_len(rst_len), .atr_len(atr_len),
    .atr_start(atr_start), .fault_clr(fault_clr), .vcc_en(vcc_en),
    .vcc_code(vcc_code), .io_rel(io_rel), .aux_rel(aux_rel), .clk_en(clk_en),
    .card_rst_n(card_rst_n), .atr_tmo(atr_tmo), .fault(fault), .state_o(state_o)
  );

  int checks = 0, errors = 0, tick_n = 0, phase = 0, cyc = 0;
  int r_vcc = -1, r_io = -1, r_clk = -1, r_rst = -1, r_ato = -1;
  int f_vcc = -1, f_io = -1, f_clk = -1, f_rst = -1, f_aux = -1;
  logic p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0, p_ato = 0, p_aux = 0;
  event mon_ev;

  always @(negedge clk) begin
    cyc++;
    if (cclk_tick) tick_n++;
    if (vcc_en === 1'b1 && !p_vcc) r_vcc = tick_n;
    if (vcc_en === 1'b0 && p_vcc)  f_vcc = tick_n;
    if (io_rel === 1'b1 && !p_io)  r_io = tick_n;
    if (io_rel === 1'b0 && p_io)   f_io = tick_n;
    if (clk_en === 1'b1 && !p_clk) r_clk = tick_n;
    if (clk_en === 1'b0 && p_clk)  f_clk = tick_n;
    if (card_rst_n === 1'b1 && !p_rst) r_rst = tick_n;
    if (card_rst_n === 1'b0 && p_rst)  f_rst = tick_n;
    if (aux_rel === 1'b0 && p_aux) f_aux = tick_n;
    if (atr_tmo === 1'b1 && !p_ato) r_ato = tick_n;
    p_vcc = (vcc_en === 1'b1); p_io = (io_rel === 1'b1); p_clk = (clk_en === 1'b1);
    p_rst = (card_rst_n === 1'b1); p_aux = (aux_rel === 1'b1); p_ato = (atr_tmo === 1'b1);
    phase = (phase == 2) ? 0 : phase + 1;
    cclk_tick = (phase == 2);
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    -> mon_ev;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(mon_ev);
  endtask

  task automatic wait_tick(input int t);
    for (int i = 0; i < 3000 && tick_n < t; i++) @(mon_ev);
  endtask

  int s;

  task automatic begin_act(input int vto, input int rdy, input int d, input logic [1:0] code);
    int t0;
    vto_len = 8'(vto); rdy_start = rdy[0]; vcc_ok = 1'b0; vsel = 2'b00; if_en = 1'b1;
    step(3);
    vsel = code; t0 = tick_n;
    for (int i = 0; i < 400 && !vcc_en; i++) step();
    s = r_vcc;
    chk("R1 supply start tick", s, t0 + 1);
    chk("R1 supply code", int'(vcc_code), int'(code));
    chk("R11 powering code", int'(state_o), 1);
    chk("R6 flag cleared on start", int'(atr_tmo), 0);
    wait_tick(s + d);
    vcc_ok = 1'b1;
  endtask

  task automatic end_act();
    if_en = 1'b0;
    for (int i = 0; i < 400 && vcc_en; i++) step();
    chk("R7 clock after reset", f_clk, f_rst + 1);
    chk("R7 io after clock", f_io, f_rst + 2);
    chk("R7 aux after io", f_aux, f_rst + 3);
    chk("R7 supply last", f_vcc, f_rst + 4);
    chk("R9 no fault on stop", int'(fault), 0);
    chk("R11 idle after stop", int'(state_o), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R12 vcc_en", int'(vcc_en), 0);
    chk("R12 io_rel", int'(io_rel), 0);
    chk("R12 clk_en", int'(clk_en), 0);
    chk("R12 card_rst_n", int'(card_rst_n), 0);
    chk("R12 flags", int'({fault, atr_tmo}), 0);
    chk("R12 state", int'(state_o), 0);

    // R2 R3 R4 R5: supply window sweep
    for (int vto = 1; vto <= 4; vto++)
      for (int rdy = 0; rdy <= 1; rdy++)
        for (int d = 0; d <= 5; d++) begin
          int io0;
          rst_len = 8'd2; atr_len = 12'd0;
          io0 = r_io;
          begin_act(vto, rdy, d, 2'b10);
          if (d + 1 <= vto) begin
            for (int i = 0; i < 400 && !card_rst_n; i++) step();
            chk("R3 io release tick", r_io, (rdy != 0) ? s + d + 3 : s + vto + 2);
            chk("R4 clock start tick", r_clk, r_io + 2);
            chk("R5 reset release tick", r_rst, r_clk + 2);
            chk("R11 atr wait code", int'(state_o), 5);
            end_act();
          end else begin
            for (int i = 0; i < 400 && vcc_en; i++) step();
            chk("R2 supply off tick", f_vcc, s + vto + 4);
            chk("R2 io never released", r_io, io0);
            chk("R2 idle after timeout", int'(state_o), 0);
          end
          vcc_ok = 1'b0; vsel = 2'b00;
        end

    // R5 R6: reset length and ATR timeout sweep
    for (int rl = 0; rl <= 4; rl++)
      for (int al = 0; al <= 3; al++) begin
        rst_len = 8'(rl); atr_len = 12'(al);
        begin_act(2, 1, 0, 2'b01);
        for (int i = 0; i < 400 && !card_rst_n; i++) step();
        chk("R5 reset length", r_rst, r_clk + ((rl == 0) ? 1 : rl));
        if (al > 0) begin
          for (int i = 0; i < 400 && !atr_tmo; i++) step();
          chk("R6 ATR timeout tick", r_ato, r_rst + al);
        end else begin
          wait_tick(r_rst + 6);
          chk("R6 timeout disabled", int'(atr_tmo), 0);
        end
        atr_start = 1'b1; step(); atr_start = 1'b0; step();
        chk("R6 active after ATR start", int'(state_o), 6);
        end_act();
        vcc_ok = 1'b0; vsel = 2'b00;
      end

    // R8: re-arm rule, then R7 stop by clearing the code
    begin_act(1, 0, 5, 2'b10);
    for (int i = 0; i < 400 && vcc_en; i++) step();
    wait_tick(tick_n + 10);
    chk("R8 no restart while code held", int'(vcc_en), 0);
    vsel = 2'b00; step(3);
    vsel = 2'b11;
    begin
      int t0;
      t0 = tick_n;
      for (int i = 0; i < 400 && !vcc_en; i++) step();
      chk("R8 restart after code cycled", r_vcc, t0 + 1);
    end
    chk("R1 5V code", int'(vcc_code), 3);
    vsel = 2'b00; step();
    chk("R7 stop on zero code", int'(state_o), 7);
    for (int i = 0; i < 400 && vcc_en; i++) step();
    chk("R7 idle after code stop", int'(state_o), 0);

    // R10: hold reset, warm reset
    hold_rst = 1'b1; rst_len = 8'd3; atr_len = 12'd0;
    begin_act(2, 1, 0, 2'b01);
    for (int i = 0; i < 400 && !clk_en; i++) step();
    wait_tick(tick_n + 8);
    chk("R10 reset held low", int'(card_rst_n), 0);
    chk("R10 reset wait code", int'(state_o), 4);
    begin
      int h;
      h = tick_n; hold_rst = 1'b0;
      for (int i = 0; i < 400 && !card_rst_n; i++) step();
      chk("R10 release after hold", r_rst, h + 3);
      atr_start = 1'b1; step(); atr_start = 1'b0; step();
      chk("R11 active code", int'(state_o), 6);
      h = tick_n; hold_rst = 1'b1;
      for (int i = 0; i < 400 && card_rst_n; i++) step();
      chk("R10 warm reset drop", f_rst, h + 1);
      chk("R10 back to reset wait", int'(state_o), 4);
      h = tick_n; hold_rst = 1'b0;
      for (int i = 0; i < 400 && !card_rst_n; i++) step();
      chk("R10 warm reset release", r_rst, h + 3);
    end

    // R9: supply loss while active
    atr_start = 1'b1; step(); atr_start = 1'b0; step();
    vcc_ok = 1'b0; step();
    chk("R9 deactivating code", int'(state_o), 7);
    chk("R9 reset dropped", int'(card_rst_n), 0);
    chk("R9 fault set", int'(fault), 1);
    for (int i = 0; i < 400 && vcc_en; i++) step();
    chk("R9 supply off after order", f_vcc, f_rst + 4);
    chk("R9 fault sticky", int'(fault), 1);
    fault_clr = 1'b1; step(); fault_clr = 1'b0; step();
    chk("R9 fault cleared", int'(fault), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule